// File: doc/BRIEF.md
# Compare-Match System Timer Pair

This block holds a free-running 64-bit system counter and two compare timers that watch it: a physical timer and a virtual timer. Each timer subtracts its own offset from the shared counter and compares the result, as an unsigned 64-bit quantity, against a programmed compare value. When the adjusted count has reached the compare value and the timer is enabled, the timer sets a status flag. It drives a level interrupt unless that interrupt is masked. The physical timer always uses an offset of zero. The virtual timer uses a 64-bit offset that software can write.

Software reaches the block through a single-cycle write port and a combinational read port that share one address. Each timer has three registers. The control register holds the enable, the mask and the read-only status. The compare register holds the full 64-bit compare value. The down-count view is a signed 32-bit window onto the compare value. A write to it sets the compare value relative to the current adjusted count. A read from it returns how far the compare value still lies ahead of the adjusted count. The counter advances by one on every clock in which the tick input is high. The source of that tick is outside this block.

Top module: `cmp_timer_pair`

## Requirements
- R1: After reset, both control registers, both compare registers, the virtual offset and the counter read 0, and both interrupt outputs are low.
- R2: The counter advances by exactly 1 at each rising clock edge where `cnt_tick` is high and holds otherwise. Its value appears on `sys_count` and is read at address 9.
- R3: A timer's status flag is 1 exactly when it is enabled and (counter − offset) ≥ compare, using unsigned 64-bit wraparound arithmetic. The flag is recomputed on each clock edge from the registered state, so it reflects any change one cycle later.
- R4: In the control register, bit 0 is enable, bit 1 is mask and bit 2 is status. A write changes only bits 1:0, and bit 2 cannot be written.
- R5: A timer's interrupt output equals status AND NOT mask. A write that changes only the mask updates the output in the cycle after the write edge, using the status already held.
- R6: While a timer is disabled, its status bit reads 0 and its interrupt output is low. This starts in the cycle right after the write that disables it.
- R7: A 64-bit write to a compare register replaces the compare value at once, and the condition is evaluated with the new value.
- R8: A write to a down-count view sets compare = (counter − offset) + sign-extended wdata[31:0]. The counter value used is the one held at the write edge, and wdata[63:32] is ignored.
- R9: A read of a down-count view returns the low 32 bits of compare − (counter − offset), zero-extended to 64 bits.
- R10: The physical timer uses offset 0 and the virtual timer uses the virtual offset register. A write to that register takes effect in the virtual timer's condition on the next evaluation and does not affect the physical timer.
- R11: Address map: 0 physical control, 1 physical compare, 2 physical down-count, 4 virtual control, 5 virtual compare, 6 virtual down-count, 8 virtual offset, 9 counter. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_tick | input | 1 | Counter advance enable for this cycle |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for write and read |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Read data for `addr` (combinational) |
| sys_count | output | 64 | Current system counter value |
| irq_phys | output | 1 | Physical timer level interrupt |
| irq_virt | output | 1 | Virtual timer level interrupt |

## Verification
The counter can step on the same clock edge that a down-count write captures the adjusted count. The bench provokes this by raising the tick and the down-count write strobe together. It then judges the result by reading the compare value and the down-count view back: the compare value must be based on the pre-increment count, and the view must already show one less than the written value. The other overlap is a counter step that carries the adjusted count across the compare value. The bench sweeps single ticks across that boundary and checks the status, the interrupt and the down-count view after each step against values computed from its own model of the counter.

// File: rtl/tmr_pkg.sv
// Shared constants for the compare-match timer pair: register address map
// and field positions of the control register.
// Assumes a 4-bit register address.
package tmr_pkg;
    localparam int ADDR_W     = 4;
    localparam int TMR_STRIDE = 4;   // address distance between timers
    localparam int CTL_OFS    = 0;
    localparam int CMP_OFS    = 1;
    localparam int DOWN_OFS   = 2;
    localparam int VOFF_ADDR  = 8;
    localparam int COUNT_ADDR = 9;
    localparam int N_TMR      = 2;   // index 0 physical, 1 virtual
    localparam int VIRT_IDX   = 1;

    localparam int CTL_EN_BIT   = 0;
    localparam int CTL_MASK_BIT = 1;
    localparam int CTL_STAT_BIT = 2;
endpackage

// File: rtl/sys_counter.sv
// Free-running system counter.
// Advances by one on each clock edge where tick is high and wraps at 2^W.
// Assumes the tick is already synchronous to clk.
module sys_counter #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    output logic [W-1:0] count
);
    // count register: clear on reset, step on tick
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (tick) count <= count + 1'b1;
    end
endmodule

// File: rtl/cmp_timer_unit.sv
// One compare timer.
// Keeps enable, mask and a compare value, and registers the firing
// condition (count - offset) >= compare on each clock edge.
// Status and interrupt are qualified by the current enable, so disabling
// the timer silences it in the very next cycle.
// Assumes at most one of the three write strobes is high in a cycle.
module cmp_timer_unit #(
    parameter int CNT_W  = 64,
    parameter int DOWN_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  count,
    input  logic [CNT_W-1:0]  offset,
    input  logic              ctl_we,
    input  logic              cmp_we,
    input  logic              down_we,
    input  logic [CNT_W-1:0]  wdata,
    output logic              en_o,
    output logic              mask_o,
    output logic              stat_o,
    output logic              irq_o,
    output logic [CNT_W-1:0]  cmp_o,
    output logic [DOWN_W-1:0] down_o
);
    localparam int EXT_W = CNT_W - DOWN_W;

    logic             en_q, mask_q, stat_q;
    logic [CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0] rel_cnt;
    logic [CNT_W-1:0] down_ext;
    logic [CNT_W-1:0] remain;

    // offset-adjusted count, signed down-count operand, distance to compare
    always_comb begin
        rel_cnt  = count - offset;
        down_ext = {{EXT_W{wdata[DOWN_W-1]}}, wdata[DOWN_W-1:0]};
        remain   = cmp_q - rel_cnt;
    end

    // control bits: only enable and mask are writable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            mask_q <= 1'b0;
        end else if (ctl_we) begin
            en_q   <= wdata[0];
            mask_q <= wdata[1];
        end
    end

    // compare value: direct load or relative load from the down-count view
    always_ff @(posedge clk) begin
        if (!rst_n)       cmp_q <= '0;
        else if (cmp_we)  cmp_q <= wdata;
        else if (down_we) cmp_q <= rel_cnt + down_ext;
    end

    // firing condition, recomputed from registered state every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= 1'b0;
        else        stat_q <= en_q && (rel_cnt >= cmp_q);
    end

    // visible outputs, gated by the current enable and mask
    always_comb begin
        en_o   = en_q;
        mask_o = mask_q;
        stat_o = stat_q & en_q;
        irq_o  = stat_q & en_q & ~mask_q;
        cmp_o  = cmp_q;
        down_o = remain[DOWN_W-1:0];
    end
endmodule

// File: rtl/cmp_timer_pair.sv
// Compare-match timer pair: shared system counter, a physical timer
// (zero offset) and a virtual timer (software offset), behind a simple
// register write port and a combinational read port.
// Assumes writes are single-cycle strobes and reads have no side effects.
module cmp_timer_pair
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 64,
    parameter int DOWN_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    output logic [CNT_W-1:0]  sys_count,
    output logic              irq_phys,
    output logic              irq_virt
);
    localparam int CTL_PAD  = CNT_W - 3;
    localparam int DOWN_PAD = CNT_W - DOWN_W;

    logic [CNT_W-1:0]  voff_q;
    logic [CNT_W-1:0]  off_a  [N_TMR];
    logic [CNT_W-1:0]  cmp_a  [N_TMR];
    logic [DOWN_W-1:0] down_a [N_TMR];
    logic [N_TMR-1:0]  en_v, mask_v, stat_v, irq_v;

    sys_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (cnt_tick),
        .count (sys_count)
    );

    // virtual offset register
    always_ff @(posedge clk) begin
        if (!rst_n)                                 voff_q <= '0;
        else if (wr_en && addr == ADDR_W'(VOFF_ADDR)) voff_q <= wdata;
    end

    for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
        localparam int BASE = i * TMR_STRIDE;
        logic ctl_we, cmp_we, down_we;

        // per-timer offset selection and write decode
        always_comb begin
            off_a[i] = (i == VIRT_IDX) ? voff_q : '0;
            ctl_we   = wr_en && (addr == ADDR_W'(BASE + CTL_OFS));
            cmp_we   = wr_en && (addr == ADDR_W'(BASE + CMP_OFS));
            down_we  = wr_en && (addr == ADDR_W'(BASE + DOWN_OFS));
        end

        cmp_timer_unit #(.CNT_W(CNT_W), .DOWN_W(DOWN_W)) u_unit (
            .clk     (clk),
            .rst_n   (rst_n),
            .count   (sys_count),
            .offset  (off_a[i]),
            .ctl_we  (ctl_we),
            .cmp_we  (cmp_we),
            .down_we (down_we),
            .wdata   (wdata),
            .en_o    (en_v[i]),
            .mask_o  (mask_v[i]),
            .stat_o  (stat_v[i]),
            .irq_o   (irq_v[i]),
            .cmp_o   (cmp_a[i]),
            .down_o  (down_a[i])
        );
    end

    // interrupt outputs
    always_comb begin
        irq_phys = irq_v[0];
        irq_virt = irq_v[VIRT_IDX];
    end

    // read multiplexer
    always_comb begin
        rdata = '0;
        for (int i = 0; i < N_TMR; i++) begin
            if (addr == ADDR_W'(i * TMR_STRIDE + CTL_OFS))
                rdata = {{CTL_PAD{1'b0}}, stat_v[i], mask_v[i], en_v[i]};
            if (addr == ADDR_W'(i * TMR_STRIDE + CMP_OFS))
                rdata = cmp_a[i];
            if (addr == ADDR_W'(i * TMR_STRIDE + DOWN_OFS))
                rdata = {{DOWN_PAD{1'b0}}, down_a[i]};
        end
        if (addr == ADDR_W'(VOFF_ADDR))  rdata = voff_q;
        if (addr == ADDR_W'(COUNT_ADDR)) rdata = sys_count;
    end
endmodule

// File: rtl/tmr_chk.sv
// Assertion checker for the compare-match timer pair, bound to the top.
// Assumes the signals it observes are those of cmp_timer_pair.
module tmr_chk #(
    parameter int CNT_W = 64,
    parameter int N     = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_tick,
    input logic [CNT_W-1:0] count,
    input logic [N-1:0]     en_v,
    input logic [N-1:0]     stat_v,
    input logic [N-1:0]     irq_v
);
    // R1
    rst_quiet_chk: assert property (@(posedge clk) !rst_n |=> (irq_v == '0));

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_tick |=> (count == $past(count) + 1'b1));

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_tick |=> $stable(count));

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R6
        dis_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !en_v[i] |-> (!irq_v[i] && !stat_v[i]));

        // R3
        stat_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(stat_v[i]) |-> $past(en_v[i]));

        // R5
        irq_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_v[i] |-> stat_v[i]);
    end
endmodule

bind cmp_timer_pair tmr_chk #(.CNT_W(CNT_W), .N(tmr_pkg::N_TMR)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_tick (cnt_tick),
    .count    (sys_count),
    .en_v     (en_v),
    .stat_v   (stat_v),
    .irq_v    (irq_v)
);

// File: tb/cmp_timer_pair_tb.sv
// Self-checking bench for cmp_timer_pair: sweeps compare, down-count and
// offset values around the current count with a bench-side counter model.
module cmp_timer_pair_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [63:0] wdata = '0;
    logic [63:0] rdata, sys_count;
    logic        irq_phys, irq_virt;

    int n_chk = 0;
    int n_err = 0;
    logic [63:0] mc = '0;   // model of the counter
    logic        done = 1'b0;

    localparam logic [3:0] PCTL = 4'd0, PCMP = 4'd1, PDOWN = 4'd2;
    localparam logic [3:0] VCTL = 4'd4, VCMP = 4'd5, VDOWN = 4'd6;
    localparam logic [3:0] VOFF = 4'd8, CNT  = 4'd9;

    always #2 clk = ~clk;

    cmp_timer_pair u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .sys_count(sys_count),
        .irq_phys(irq_phys), .irq_virt(irq_virt)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [63:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run(input int n);
        @(negedge clk);
        cnt_tick = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
        cnt_tick = 1'b0;
        mc = mc + 64'(n);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog act=%h exp=%h", 64'd0, 64'd1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [63:0] r, cmp, off;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 irq_phys", {63'd0, irq_phys}, 64'd0);
        chk("R1 irq_virt", {63'd0, irq_virt}, 64'd0);
        rst_n = 1'b1;
        step();
        foreach (r[k]) if (k < 10) begin
            logic [63:0] v;
            rd(4'(k), v);
            chk("R1 R11 reset read", v, 64'd0);
        end

        // R2: counter advance and hold
        run(100);
        rd(CNT, r); chk("R2 count", r, mc);
        step(); step();
        rd(CNT, r); chk("R2 hold", r, mc);
        chk("R2 sys_count", sys_count, mc);

        // R4: control field, status read-only
        wr(PCTL, 64'h7); step();
        rd(PCTL, r); chk("R4 ctl en+mask+stat", r, 64'h7);
        chk("R5 masked irq", {63'd0, irq_phys}, 64'd0);
        wr(PCTL, 64'hFFFF_FFFF_FFFF_FFFC); step();
        rd(PCTL, r); chk("R4 R6 stat not writable", r, 64'h0);

        // R7 R3: compare sweep around count, timer enabled and unmasked
        wr(PCTL, 64'h1);
        for (int d = -3; d <= 3; d++) begin
            cmp = mc + 64'(d);
            wr(PCMP, cmp);
            rd(PCMP, r); chk("R7 cmp readback", r, cmp);
            step();
            rd(PCTL, r); chk("R3 status", r, {61'd0, (mc >= cmp), 2'b01});
            chk("R5 irq_phys", {63'd0, irq_phys}, {63'd0, (mc >= cmp)});
        end

        // R5: mask toggle uses existing status at once
        wr(PCMP, mc - 64'd50); step();
        wr(PCTL, 64'h3);
        chk("R5 mask on", {63'd0, irq_phys}, 64'd0);
        rd(PCTL, r); chk("R5 status kept", r, 64'h7);
        wr(PCTL, 64'h1);
        chk("R5 mask off", {63'd0, irq_phys}, 64'd1);

        // R6: disabling silences next cycle
        wr(PCTL, 64'h0);
        chk("R6 irq off", {63'd0, irq_phys}, 64'd0);
        rd(PCTL, r); chk("R6 status off", r, 64'h0);
        wr(PCTL, 64'h1);

        // R8 R9: down-count writes, upper bits ignored
        for (int v = -3; v <= 3; v++) begin
            wr(PDOWN, {32'hDEAD_BEEF, 32'(v)});
            cmp = mc + 64'(v);
            rd(PCMP, r); chk("R8 cmp from down", r, cmp);
            rd(PDOWN, r); chk("R9 down read", r, {32'd0, 32'(v)});
            step();
            chk("R3 irq from down", {63'd0, irq_phys}, {63'd0, (v <= 0)});
        end

        // R3 R9: single ticks across the compare point
        wr(PCMP, mc + 64'd4);
        cmp = mc + 64'd4;
        for (int k = 1; k <= 7; k++) begin
            run(1);
            step();
            rd(PCTL, r); chk("R3 tick status", r, {61'd0, (mc >= cmp), 2'b01});
            rd(PDOWN, r); chk("R9 tick down", r, {32'd0, 32'(cmp - mc)});
        end

        // R8: down-count write on the same edge as a counter step
        @(negedge clk);
        cnt_tick = 1'b1; wr_en = 1'b1; addr = PDOWN; wdata = 64'd3;
        @(posedge clk);
        @(negedge clk);
        cnt_tick = 1'b0; wr_en = 1'b0;
        rd(PCMP, r); chk("R8 concurrent cmp", r, mc + 64'd3);
        mc = mc + 64'd1;
        rd(PDOWN, r); chk("R9 concurrent down", r, 64'd2);

        // R10: virtual timer offset sweep, physical unaffected
        wr(PCMP, mc + 64'd1);
        wr(VCMP, 64'd10);
        wr(VCTL, 64'h1);
        for (int j = 0; j < 4; j++) begin
            case (j)
                0: off = mc - 64'd12;
                1: off = mc - 64'd10;
                2: off = mc - 64'd9;
                default: off = mc + 64'd1;
            endcase
            wr(VOFF, off);
            rd(VOFF, r); chk("R10 voff readback", r, off);
            step();
            chk("R10 irq_virt", {63'd0, irq_virt}, {63'd0, ((mc - off) >= 64'd10)});
            chk("R10 phys unaffected", {63'd0, irq_phys}, 64'd0);
        end
        wr(VDOWN, 64'd5);
        rd(VCMP, r); chk("R8 R10 virt down", r, mc - off + 64'd5);
        rd(VDOWN, r); chk("R9 virt down read", r, 64'd5);

        // R11: unmapped addresses read zero
        rd(4'd3, r);  chk("R11 addr3", r, 64'd0);
        rd(4'd7, r);  chk("R11 addr7", r, 64'd0);
        rd(4'd15, r); chk("R11 addr15", r, 64'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule